// File: doc/BRIEF.md
# Embedded-Sync Video Frame Tracker

This block watches an 8-bit video byte stream that carries its timing inside the data, as in BT.656. It finds the four-byte timing reference codes and pulls out the field, vertical-blanking and horizontal flags. It then produces one-cycle start-of-frame and start-of-line pulses. In interlaced mode a frame begins where the field flag falls. In progressive mode it begins where the vertical-blanking flag falls. Only codes that end active video (EAV) are used for frame timing.

Once locked, the block counts lines between frame boundaries. A line is one EAV followed by a start-of-active-video code (SAV). At each boundary the count is compared with a programmed expected value, and any difference raises a sticky error. A field flag toggles each time a complete field has arrived, so software can tell which field was just captured. Any partial frame seen before lock is discarded. A frame that lost a line flags once, and tracking recovers at the next boundary.

Top module: `vft_frame_tracker`

## Requirements
- R1: Bytes count only in cycles where `byte_vld` is high. A timing code is the byte run 0xFF, 0x00, 0x00 followed by a flag byte. The flag byte must have bit 7 set; bit 6 is F, bit 5 is V and bit 4 is H. A flag byte with bit 7 clear is not a code. H=1 marks an EAV and H=0 marks an SAV.
- R2: `sol` pulses for exactly one cycle for each EAV whose previous accepted code was an SAV.
- R3: In interlaced mode, `sof` pulses when F goes from 1 to 0 between two successive EAVs. The F and V bits of SAV codes never affect frame timing.
- R4: In progressive mode (`interlaced` low), `sof` pulses when V goes from 1 to 0 between two successive EAVs.
- R5: `in_sync` is low after reset and stays low until the first `sof`. After that it stays high until reset.
- R6: Lines seen before `in_sync` is high are not counted, and no comparison is made at the first `sof`.
- R7: Between two successive `sof` pulses, the block counts each SAV whose previous code was an EAV. At the closing `sof`, a count that differs from `exp_lines` in either direction sets `track_err`.
- R8: `track_err` stays high until `err_clr` is pulsed. If a mismatch and `err_clr` fall in the same cycle, the error stays set.
- R9: `field_flag` is 0 after reset and toggles only while `in_sync` is already high. In interlaced mode it toggles on every F change between successive EAVs. In progressive mode it toggles on every `sof` after the first.
- R10: After a frame with a missing SAV, the next frame with the correct line count raises no new error.
- R11: Suppose the flag byte of a code is sampled at clock edge n. Then `sof` and `sol` are still low after edge n, are high from edge n+1, and are low again after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Byte qualifier |
| byte_in | input | 8 | Video stream byte |
| interlaced | input | 1 | 1: frames by F falling edge, 0: frames by V falling edge |
| exp_lines | input | LINE_W | Expected lines per frame |
| err_clr | input | 1 | Write-one-to-clear pulse for the error |
| sof | output | 1 | Start-of-frame pulse |
| sol | output | 1 | Start-of-line pulse |
| in_sync | output | 1 | High after the first frame boundary |
| field_flag | output | 1 | Toggles once per complete field |
| track_err | output | 1 | Sticky line-count mismatch |

## Verification
On every cycle, the assertions check the following:
- a decoded code always comes from a qualified byte with bit 7 set;
- `sof` and `sol` each follow an EAV of the right kind;
- lock never drops;
- the field flag moves only on a code while locked;
- the error rises only at a frame close and holds until it is cleared.

The bench scenarios show what a property cannot see: the actual line totals, rejection of bad preambles and of invalid-cycle bytes, the field parity over many frames, and recovery after a dropped SAV. It sweeps both modes over three line counts each, using short frames, plus drop and extra-line cases.

// File: rtl/vft_pkg.sv
package vft_pkg;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    typedef enum logic [1:0] {
        SEEK_FF,
        SEEK_Z1,
        SEEK_Z2,
        SEEK_XY
    } trs_state_t;

    localparam logic [7:0] PRE_ONES  = 8'hFF;
    localparam logic [7:0] PRE_ZEROS = 8'h00;

    function automatic trs_flags_t xy_flags(input logic [7:0] b);
        trs_flags_t r;
        r.f = b[6];
        r.v = b[5];
        r.h = b[4];
        return r;
    endfunction

    function automatic trs_state_t restart(input logic [7:0] b);
        return (b == PRE_ONES) ? SEEK_Z1 : SEEK_FF;
    endfunction

endpackage

// File: rtl/vft_trs_detect.sv
module vft_trs_detect
    import vft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       vld,
    input  logic [7:0] din,
    output logic       code_vld,
    output trs_flags_t code
);

    trs_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SEEK_FF;
            code_vld <= 1'b0;
            code     <= '0;
        end else begin
            code_vld <= 1'b0;
            if (vld) begin
                case (st)
                    SEEK_FF: st <= restart(din);
                    SEEK_Z1: st <= (din == PRE_ZEROS) ? SEEK_Z2 : restart(din);
                    SEEK_Z2: st <= (din == PRE_ZEROS) ? SEEK_XY : restart(din);
                    default: begin
                        if (din[7]) begin
                            code_vld <= 1'b1;
                            code     <= xy_flags(din);
                        end
                        st <= restart(din);
                    end
                endcase
            end
        end
    end

    // R1
    code_src_chk: assert property (@(posedge clk) disable iff (rst)
        code_vld |-> $past(vld && din[7]));

endmodule

// File: rtl/vft_sync_edges.sv
module vft_sync_edges
    import vft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       code_vld,
    input  trs_flags_t code,
    input  logic       interlaced,
    output logic       sof,
    output logic       sol,
    output logic       line_tick,
    output logic       close,
    output logic       in_sync,
    output logic       field_flag
);

    logic eav_seen, any_code, f_last, v_last, h_last;
    logic is_eav, is_sav, f_fall, f_rise, v_fall, bound, fld_n;

    always_comb begin
        is_eav = code_vld & code.h;
        is_sav = code_vld & ~code.h;
        f_fall = is_eav & eav_seen & f_last & ~code.f;
        f_rise = is_eav & eav_seen & ~f_last & code.f;
        v_fall = is_eav & eav_seen & v_last & ~code.v;
        bound  = interlaced ? f_fall : v_fall;
        fld_n  = in_sync & (interlaced ? (f_fall | f_rise) : v_fall);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eav_seen   <= 1'b0;
            any_code   <= 1'b0;
            f_last     <= 1'b0;
            v_last     <= 1'b0;
            h_last     <= 1'b0;
            sof        <= 1'b0;
            sol        <= 1'b0;
            line_tick  <= 1'b0;
            close      <= 1'b0;
            in_sync    <= 1'b0;
            field_flag <= 1'b0;
        end else begin
            sof       <= bound;
            close     <= bound & in_sync;
            sol       <= is_eav & any_code & ~h_last;
            line_tick <= is_sav & any_code & h_last;
            if (bound) in_sync <= 1'b1;
            if (fld_n) field_flag <= ~field_flag;
            if (code_vld) begin
                any_code <= 1'b1;
                h_last   <= code.h;
                if (code.h) begin
                    eav_seen <= 1'b1;
                    f_last   <= code.f;
                    v_last   <= code.v;
                end
            end
        end
    end

    // R5
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        in_sync |=> in_sync);
    // R2
    sol_src_chk: assert property (@(posedge clk) disable iff (rst)
        sol |-> $past(code_vld && code.h));
    // R3, R4
    sof_fall_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> $past(code_vld && code.h && (interlaced ? !code.f : !code.v)));
    // R9
    field_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_flag) |-> $past(code_vld && in_sync));

endmodule

// File: rtl/vft_line_check.sv
module vft_line_check #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              sof,
    input  logic              close,
    input  logic              in_sync,
    input  logic [LINE_W-1:0] exp_lines,
    input  logic              err_clr,
    output logic              track_err
);

    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    logic [LINE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            track_err <= 1'b0;
        end else begin
            if (sof)
                cnt <= '0;
            else if (line_tick && in_sync && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;

            if (close && cnt != exp_lines)
                track_err <= 1'b1;
            else if (err_clr)
                track_err <= 1'b0;
        end
    end

    // R6
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_sync |-> cnt == '0);
    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(track_err) |-> $past(close));
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        track_err && !err_clr |=> track_err);

endmodule

// File: rtl/vft_frame_tracker.sv
module vft_frame_tracker
    import vft_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              interlaced,
    input  logic [LINE_W-1:0] exp_lines,
    input  logic              err_clr,
    output logic              sof,
    output logic              sol,
    output logic              in_sync,
    output logic              field_flag,
    output logic              track_err
);

    logic       code_vld;
    trs_flags_t code;
    logic       line_tick, close;

    vft_trs_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .vld      (byte_vld),
        .din      (byte_in),
        .code_vld (code_vld),
        .code     (code)
    );

    vft_sync_edges u_edges (
        .clk        (clk),
        .rst        (rst),
        .code_vld   (code_vld),
        .code       (code),
        .interlaced (interlaced),
        .sof        (sof),
        .sol        (sol),
        .line_tick  (line_tick),
        .close      (close),
        .in_sync    (in_sync),
        .field_flag (field_flag)
    );

    vft_line_check #(.LINE_W(LINE_W)) u_check (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .sof       (sof),
        .close     (close),
        .in_sync   (in_sync),
        .exp_lines (exp_lines),
        .err_clr   (err_clr),
        .track_err (track_err)
    );

endmodule

// File: tb/vft_frame_tracker_tb.sv
module vft_frame_tracker_tb;

    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_in = 8'hFF;
    logic          interlaced = 1'b0;
    logic [LW-1:0] exp_lines = '0;
    logic          err_clr = 1'b0;
    logic          sof, sol, in_sync, field_flag, track_err;

    int n_chk = 0, n_bad = 0;
    int sof_cnt = 0, sol_cnt = 0;
    int m_sof, m_sol, m_lines;
    bit m_err, m_field, m_sync, last_h, have_code;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vft_frame_tracker #(.LINE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .interlaced(interlaced), .exp_lines(exp_lines), .err_clr(err_clr),
        .sof(sof), .sol(sol), .in_sync(in_sync), .field_flag(field_flag),
        .track_err(track_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sof) sof_cnt++;
            if (sol) sol_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        byte_in  = b;
        byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        byte_in  = 8'hFF;   // junk while not qualified
    endtask

    task automatic trs(input bit f, input bit v, input bit h);
        put(8'hFF); put(8'h00); put(8'h00);
        put({1'b1, f, v, h, 4'b0000});
        if (h && have_code && !last_h) m_sol++;
        if (!h && have_code && last_h && m_sync) m_lines++;
        last_h    = h;
        have_code = 1'b1;
    endtask

    // ev: 0 none, 1 frame start, 2 field change only
    task automatic line(input bit f, input bit v, input bit drop, input int ev);
        if (ev == 1) begin
            if (m_sync) begin
                if (m_lines != int'(exp_lines)) m_err = 1'b1;
                m_field = ~m_field;
            end
            m_lines = 0;
            m_sync  = 1'b1;
            m_sof++;
        end else if (ev == 2 && m_sync) begin
            m_field = ~m_field;
        end
        trs(f, v, 1'b1);
        if (ev == 1) begin
            check("R11 sof low after flag edge", int'(sof), 0);
            @(negedge clk);
            check("R11 sof high one edge later", int'(sof), 1);
        end
        put(8'h10); put(8'h80);
        if (!drop) trs(f, v, 1'b0);
        put(8'h10); put(8'h80);
    endtask

    task automatic frame(input int act, input bit drop);
        if (interlaced) begin
            line(1'b0, 1'b1, 1'b0, 1);
            for (int i = 0; i < act; i++) line(1'b0, 1'b0, drop && i == act - 1, 0);
            line(1'b1, 1'b1, 1'b0, 2);
            for (int i = 0; i < act; i++) line(1'b1, 1'b0, 1'b0, 0);
        end else begin
            line(1'b1, 1'b1, 1'b0, 0);
            for (int i = 0; i < act; i++) line(1'b0, 1'b0, drop && i == act - 1, i == 0 ? 1 : 0);
        end
    endtask

    task automatic frame_checks(input string tag);
        check({tag, " R5 in_sync"}, int'(in_sync), 1);
        check({tag, " R7 track_err"}, int'(track_err), int'(m_err));
        check({tag, " R9 field_flag"}, int'(field_flag), int'(m_field));
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        m_err = 1'b0;
        check("R8 cleared by err_clr", int'(track_err), 0);
    endtask

    task automatic run_cfg(input bit mode, input int lines);
        int act;
        interlaced = mode;
        exp_lines  = LW'(lines);
        act = mode ? (lines / 2 - 1) : (lines - 1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sof_cnt = 0; sol_cnt = 0;
        m_sof = 0; m_sol = 0; m_lines = 0;
        m_err = 0; m_field = 0; m_sync = 0; last_h = 0; have_code = 0;
        @(negedge clk);
        check("R5 reset in_sync", int'(in_sync), 0);
        check("R8 reset track_err", int'(track_err), 0);
        check("R9 reset field_flag", int'(field_flag), 0);
        // lead-in: SAVs with F=V=0 and a bad flag byte must do nothing
        trs(1'b1, 1'b1, 1'b1);
        put(8'hFF); put(8'h00); put(8'h00); put(8'h20);
        trs(1'b1, 1'b1, 1'b1);
        trs(1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R3 R4 no sof from SAV flags", sof_cnt, 0);
        check("R1 bit7-clear byte rejected", sol_cnt, m_sol);
        check("R5 still unsynced", int'(in_sync), 0);
        frame(act, 1'b0); frame_checks("f1 R6");
        frame(act, 1'b0); frame_checks("f2");
        frame(act, 1'b1); frame_checks("f3");
        frame(act, 1'b0); frame_checks("f4 missed SAV");
        check("R7 drop flagged", int'(track_err), 1);
        frame(act, 1'b0); frame_checks("f5 R8 sticky");
        clear_err();
        frame(act, 1'b0); frame_checks("f6 R10 resync");
        check("R10 no new error", int'(track_err), 0);
        frame(act + 1, 1'b0); frame_checks("f7");
        frame(act, 1'b0); frame_checks("f8 extra line");
        check("R7 extra line flagged", int'(track_err), 1);
        clear_err();
        repeat (3) @(negedge clk);
        check("R3 R4 sof count", sof_cnt, m_sof);
        check("R2 sol count", sol_cnt, m_sol);
    endtask

    initial begin
        for (int n = 3; n <= 5; n++) run_cfg(1'b0, n);
        for (int n = 4; n <= 8; n += 2) run_cfg(1'b1, n);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule